// File: doc/BRIEF.md
# USB Low-Speed Packet Serializer

This block turns a short packet, handed over one byte at a time, into line symbols on a USB low-speed D+/D- pair. A single start strobe carries the number of payload bytes. The block first places the idle J level on the lines and only then enables its drivers. It sends the sync byte, then asks for each payload byte in turn and shifts it out least significant bit first. Every bit is NRZI encoded, and a stuffed bit follows any run of six ones.

When the last bit has left, including a stuffed bit that may trail it, the block drives single-ended zero for two bit times and J for one bit time. It then drops the output enable and reports completion. A handshake such as ACK or NAK is sent as a packet with one payload byte. The bit-rate clock runs at a fixed multiple of the line bit rate, and each line symbol lasts that many cycles.

Top module: `usb_ls_tx`

## Requirements
- R1: While reset is held and after it is released, oe, busy, done and byte_req are 0 and both dp and dm are 0.
- R2: In the cycle after an accepted start, busy is 1, oe is 0 and the lines show J (dp=0, dm=1). oe rises in the next cycle.
- R3: Every line symbol, stuffed symbols included, lasts exactly BIT_CYCLES clock cycles (8 by default). The first symbol begins in the cycle in which oe rises.
- R4: The bit stream is the sync byte 0x80 followed by byte_count payload bytes, each sent least significant bit first. A byte_count of 0 sends the sync byte alone.
- R5: The lines use NRZI coding that starts from J. A 0 bit flips the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the level.
- R6: After six consecutive 1 bits, an extra symbol that flips the line is inserted and the run count restarts. The count runs on from the sync byte and across byte boundaries.
- R7: byte_req is high for exactly one cycle per payload byte, byte_count times per packet in total. byte_data is taken in that same cycle, which is the last cycle of bit 7 of the byte before it.
- R8: After the last symbol, which may be a stuffed bit that follows the final data bit, the lines show SE0 (dp=0, dm=0) for two bit times with oe high, then J for one bit time, and then oe falls.
- R9: busy stays high from the cycle after the start until the cycle in which oe falls. done is a one-cycle pulse in the first cycle with oe low.
- R10: A start pulse that arrives while busy is high has no effect on the packet being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, BIT_CYCLES cycles per line bit |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a packet; accepted only while idle |
| byte_count | input | CNT_W | Payload byte count, taken with start |
| byte_req | output | 1 | Request strobe; byte_data is taken in this cycle |
| byte_data | input | 8 | Next payload byte |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse once the drivers are released |

## Verification
The hardest case to reach is a stuffed bit that falls after bit 7 of the final byte, right before end-of-packet. Stuffing that spans the sync byte and several payload bytes is nearly as hard. The stimulus reaches the first case with a single payload byte 0xFC, whose last six bits are ones. It reaches the second with three bytes of 0xFF, where the sync byte's trailing one starts the run and stuffed bits land at bit positions 4, 2, 0 and 6 of successive bytes. The bench builds the expected symbol list from the requirements and samples the first and last cycle of every symbol. This catches both misplaced stuffing and wrong symbol lengths.

// File: rtl/usb_ls_tx_pkg.sv
// Shared definitions for the low-speed serializer: controller states,
// line symbol codes written as {dp, dm}, and the sync pattern.
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_BIT  = 3'd2,
        ST_SE0  = 3'd3,
        ST_JEND = 3'd4
    } tx_state_e;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;

    localparam logic [7:0] SYNC_BYTE = 8'h80;

endpackage

// File: rtl/usb_ls_tx_timer.sv
// Bit period timer.
// What it does: counts clock cycles while run is high and raises tick in
// the final cycle of each bit period.
// Assumes: run stays high without a break for the whole packet body, so
// that bit periods line up back to back; the count clears while run is low.
module usb_ls_tx_timer #(
    parameter int BIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Cycle counter, wraps at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/usb_ls_tx_stuffer.sv
// Bit source with stuffing.
// What it does: holds the byte being sent, picks the bit of the current
// slot, counts consecutive ones and inserts a stuffed slot after RUN_LEN of
// them. It asks for the next payload byte at the end of bit 7 and reports
// whether the current slot is the last one of the packet.
// Assumes: load comes while no packet is active; advance pulses once at
// the end of every slot; byte_data is valid in the cycle byte_req is high.
module usb_ls_tx_stuffer #(
    parameter int CNT_W   = 8,
    parameter int RUN_LEN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    input  logic             advance,
    input  logic [7:0]       byte_data,
    output logic             toggle,
    output logic             last_slot,
    output logic             byte_req
);
    import usb_ls_tx_pkg::*;

    localparam int OW = $clog2(RUN_LEN + 2);
    localparam logic [OW-1:0] RUN_MAX = OW'(RUN_LEN);

    logic [7:0]       shreg;
    logic [2:0]       bit_idx;
    logic [OW-1:0]    ones;
    logic             cur_stuff;
    logic             drained;
    logic [CNT_W-1:0] bytes_left;

    logic [OW-1:0]    ones_n;
    logic             stuff_next;
    logic             at_bit7;
    logic             more;

    // Run length after the current data bit, and whether a stuff slot follows.
    always_comb begin
        ones_n     = shreg[0] ? (ones + 1'b1) : '0;
        stuff_next = (ones_n == RUN_MAX);
        at_bit7    = (bit_idx == 3'd7);
        more       = (bytes_left != '0);
    end

    assign toggle    = cur_stuff | ~shreg[0];
    assign last_slot = cur_stuff ? drained : (at_bit7 && !more && !stuff_next);
    assign byte_req  = advance && !cur_stuff && at_bit7 && more;

    // Slot sequencing: shift data, insert stuffed slots, fetch bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            ones       <= '0;
            cur_stuff  <= 1'b0;
            drained    <= 1'b0;
            bytes_left <= '0;
        end else if (load) begin
            shreg      <= SYNC_BYTE;
            bit_idx    <= '0;
            ones       <= '0;
            cur_stuff  <= 1'b0;
            drained    <= 1'b0;
            bytes_left <= count_in;
        end else if (advance) begin
            if (cur_stuff) begin
                cur_stuff <= 1'b0;
            end else begin
                cur_stuff <= stuff_next;
                ones      <= stuff_next ? '0 : ones_n;
                if (at_bit7) begin
                    bit_idx <= '0;
                    if (more) begin
                        shreg      <= byte_data;
                        bytes_left <= bytes_left - 1'b1;
                    end else begin
                        drained <= 1'b1;
                    end
                end else begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx_nrzi.sv
// NRZI level keeper.
// What it does: keeps the line level left by the previous slot (1 = J).
// The level of the current slot is that level, flipped when toggle is set.
// Assumes: init comes with the packet start; advance pulses at each slot end.
module usb_ls_tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic advance,
    input  logic toggle,
    output logic cur_j
);
    logic ref_j;

    assign cur_j = toggle ? ~ref_j : ref_j;

    // Commit the current slot's level as the next reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_j <= 1'b1;
        end else if (init) begin
            ref_j <= 1'b1;
        end else if (advance) begin
            ref_j <= cur_j;
        end
    end

endmodule

// File: rtl/usb_ls_tx.sv
// Low-speed USB packet serializer, top level.
// What it does: on start, parks the lines at J for one cycle, enables the
// drivers, sends the sync byte and the payload through the stuffer and NRZI
// stages, then drives SE0 for two bit times and J for one, and releases.
// Assumes: clk runs at BIT_CYCLES times the line bit rate; the byte source
// answers byte_req in the same cycle.
module usb_ls_tx #(
    parameter int BIT_CYCLES = 8,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    output logic             byte_req,
    input  logic [7:0]       byte_data,
    output logic             dp,
    output logic             dm,
    output logic             oe,
    output logic             busy,
    output logic             done
);
    import usb_ls_tx_pkg::*;

    localparam int SE0_BITS = 2;
    localparam int SW = $clog2(SE0_BITS + 1);
    localparam logic [SW-1:0] SE0_LAST = SW'(SE0_BITS - 1);

    tx_state_e     state;
    logic [SW-1:0] se0_cnt;
    logic          done_q;
    logic          accept;
    logic          run;
    logic          bit_tick;
    logic          advance;
    logic          toggle;
    logic          last_slot;
    logic          cur_j;
    logic [1:0]    line;

    assign accept  = (state == ST_IDLE) && start;
    assign run     = (state == ST_BIT) || (state == ST_SE0) || (state == ST_JEND);
    assign advance = (state == ST_BIT) && bit_tick;

    usb_ls_tx_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (bit_tick)
    );

    usb_ls_tx_stuffer #(.CNT_W(CNT_W), .RUN_LEN(6)) u_stuffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .count_in  (byte_count),
        .advance   (advance),
        .byte_data (byte_data),
        .toggle    (toggle),
        .last_slot (last_slot),
        .byte_req  (byte_req)
    );

    usb_ls_tx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (accept),
        .advance (advance),
        .toggle  (toggle),
        .cur_j   (cur_j)
    );

    // Packet phase sequencing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            se0_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) state <= ST_PREP;
                ST_PREP: state <= ST_BIT;
                ST_BIT: begin
                    if (bit_tick && last_slot) begin
                        state   <= ST_SE0;
                        se0_cnt <= '0;
                    end
                end
                ST_SE0: begin
                    if (bit_tick) begin
                        if (se0_cnt == SE0_LAST) state <= ST_JEND;
                        else se0_cnt <= se0_cnt + 1'b1;
                    end
                end
                ST_JEND: begin
                    if (bit_tick) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line symbol and driver enable for each phase.
    always_comb begin
        line = LINE_SE0;
        oe   = 1'b0;
        case (state)
            ST_PREP: line = LINE_J;
            ST_BIT: begin
                line = cur_j ? LINE_J : LINE_K;
                oe   = 1'b1;
            end
            ST_SE0: oe = 1'b1;
            ST_JEND: begin
                line = LINE_J;
                oe   = 1'b1;
            end
            default: line = LINE_SE0;
        endcase
    end

    assign dp   = line[1];
    assign dm   = line[0];
    assign busy = (state != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
// Protocol checker for usb_ls_tx, bound into every instance.
// What it does: watches driver hand-over, symbol timing and status pulses.
// Assumes: tick is the bit timer's end-of-period strobe.
module usb_ls_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic dp,
    input logic dm,
    input logic oe,
    input logic busy,
    input logic done,
    input logic byte_req,
    input logic tick
);
    // R2: lines sat at J in the cycle before the drivers came on
    p_j_before_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> ($past({dp, dm}) == 2'b01) && busy);

    // R3: a driven symbol changes only at a bit period boundary
    p_symbol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(tick)) |-> $stable({dp, dm}));

    // R7: byte requests only while the packet body is on the wire
    p_req_in_packet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> (oe && busy));

    // R9: done marks the first cycle after release
    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!oe && !busy && $past(oe)));

    // R9: drivers are enabled only inside a busy period
    p_oe_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> busy);

endmodule

bind usb_ls_tx usb_ls_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp       (dp),
    .dm       (dm),
    .oe       (oe),
    .busy     (busy),
    .done     (done),
    .byte_req (byte_req),
    .tick     (bit_tick)
);

// File: tb/usb_ls_tx_bench.sv
// Directed bench for usb_ls_tx: each task sends one packet shape and checks
// every symbol against a list built from the requirements.
module usb_ls_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_count = 8'd0;
    logic       byte_req;
    logic [7:0] byte_data;
    logic       dp, dm, oe, busy, done;

    always #4 clk = ~clk;

    usb_ls_tx u_usb_ls_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_count (byte_count),
        .byte_req   (byte_req),
        .byte_data  (byte_data),
        .dp         (dp),
        .dm         (dm),
        .oe         (oe),
        .busy       (busy),
        .done       (done)
    );

    logic [7:0] pay [0:7];
    int idx = 0;
    int req_cnt = 0;
    int n_tests = 0;
    int n_fail = 0;
    logic [1:0] exp_sym [0:255];
    int n_sym;

    assign byte_data = pay[idx[2:0]];

    always @(posedge clk) begin
        if (byte_req) begin
            idx     <= idx + 1;
            req_cnt <= req_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected symbols: NRZI from J, stuffing after six ones, then EOP.
    task automatic build(input int cnt);
        int  ones = 0;
        bit  lvl = 1'b1;
        n_sym = 0;
        for (int i = 0; i <= cnt; i++) begin
            logic [7:0] b = (i == 0) ? 8'h80 : pay[i-1];
            for (int k = 0; k < 8; k++) begin
                if (!b[k]) begin
                    lvl = !lvl;
                    ones = 0;
                end else begin
                    ones++;
                end
                exp_sym[n_sym] = lvl ? 2'b01 : 2'b10;
                n_sym++;
                if (ones == 6) begin
                    lvl = !lvl;
                    ones = 0;
                    exp_sym[n_sym] = lvl ? 2'b01 : 2'b10;
                    n_sym++;
                end
            end
        end
        exp_sym[n_sym] = 2'b00; n_sym++;
        exp_sym[n_sym] = 2'b00; n_sym++;
        exp_sym[n_sym] = 2'b01; n_sym++;
    endtask

    task automatic send(input int cnt, input string req, input int poke_slot);
        build(cnt);
        idx = 0;
        req_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        byte_count = 8'(cnt);
        @(negedge clk);
        start = 1'b0;
        chk(busy && !oe && ({dp, dm} == 2'b01), "R2", "prep cycle",
            {busy, oe, dp, dm}, 4'b1001);
        @(negedge clk);
        for (int s = 0; s < n_sym; s++) begin
            if (s == poke_slot) start = 1'b1;
            chk({oe, dp, dm} == {1'b1, exp_sym[s]}, req,
                $sformatf("slot %0d first cycle", s), {oe, dp, dm}, {1'b1, exp_sym[s]});
            @(negedge clk);
            start = 1'b0;
            repeat (6) @(negedge clk);
            chk({oe, dp, dm} == {1'b1, exp_sym[s]}, req,
                $sformatf("slot %0d last cycle", s), {oe, dp, dm}, {1'b1, exp_sym[s]});
            @(negedge clk);
        end
        chk(!oe && !busy && done, "R9", "release with done", {oe, busy, done}, 3'b001);
        chk(req_cnt == cnt, "R7", "byte request count", req_cnt, cnt);
        @(negedge clk);
        chk(!done && !busy, "R9", "done is one cycle", {done, busy}, 2'b00);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({oe, busy, done, byte_req, dp, dm} == 6'b0, "R1", "in reset",
            {oe, busy, done, byte_req, dp, dm}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({oe, busy, done, byte_req, dp, dm} == 6'b0, "R1", "after reset",
            {oe, busy, done, byte_req, dp, dm}, 0);
    endtask

    task automatic t_handshake;
        pay[0] = 8'hD2;
        send(1, "R5", -1);
    endtask

    task automatic t_sync_only;
        send(0, "R4", -1);
    endtask

    task automatic t_mixed_bytes;
        pay[0] = 8'h00; pay[1] = 8'h55; pay[2] = 8'hC3; pay[3] = 8'h81;
        send(4, "R3", -1);
    endtask

    task automatic t_long_ones;
        pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hFF;
        send(3, "R6", -1);
    endtask

    task automatic t_tail_stuff;
        pay[0] = 8'hFC;
        send(1, "R8", -1);
    endtask

    task automatic t_start_while_busy;
        pay[0] = 8'h3C; pay[1] = 8'hA5;
        send(2, "R10", 3);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) pay[i] = 8'h00;
        t_reset();
        t_handshake();
        t_sync_only();
        t_mixed_bytes();
        t_long_ones();
        t_tail_stuff();
        t_start_while_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule